// File: doc/BRIEF.md
# Armed capture buffer controller

This block runs one acquisition at a time into a circular store of 1024 entries, each holding a 10-bit analog value and an 8-bit logic value packed as 24 bits. A host writes an 8-bit control value to arm or abandon a capture, or to force one. An external trigger pulse, or a forced start, ends the pre-trigger phase, and a fixed number of further samples completes the record.

The host polls the capture state with a one-cycle query and receives a status byte on the next cycle. Once the byte reads "ready", a dump request streams the whole record as three bytes per sample, one byte per cycle. The stream starts with the oldest stored sample. Trigger generation, sample-rate division and the host link sit outside this block.

Top module: `armed_capture_ctrl`

## Requirements
- R1: After reset the state is idle. A status query returns 0x00, and dout_valid stays low.
- R2: Control bit 0 is the FSM reset. While the latest written control value has it set, the state is forced to idle from any state, and this overrides arm and force. A query then returns 0x00.
- R3: A write whose bit 1 (arm) is set, when the previously written value had bit 1 clear, starts a fresh capture. The state becomes filling (status 0x01) and storage restarts at slot 0.
- R4: In the filling state every sample with smp_valid high is stored. After PRE_SAMPLES samples the state becomes waiting (status 0x02). A trigger pulse while filling is ignored.
- R5: In the waiting state, storage continues around the circular buffer. trig_i high at a clock edge moves the state to post-trigger filling (status 0x03).
- R6: A write whose bit 3 (force) is set, when the previous value had bit 3 clear, moves the filling or waiting state to post-trigger filling without any trigger.
- R7: After DEPTH-PRE_SAMPLES more samples in post-trigger filling, the state becomes ready (status 0x04). Later samples are not stored.
- R8: Writing a control value that keeps bit 1 or bit 3 set when it was already set has no effect on the state.
- R9: A status_req pulse gives status_valid for exactly the next cycle, with status_byte holding the state code from before the request edge. Codes are idle 0x00, filling 0x01, waiting 0x02, post 0x03 and ready 0x04.
- R10: A dump request seen in the ready state produces 3*DEPTH bytes on consecutive cycles, starting two cycles after the request. The first byte belongs to the slot just after the last written one. A request in any other state is ignored.
- R11: Each sample is sent as three bytes, and the top two bits of every byte are zero. Byte 0 bits 5:0 carry analog 5:0. Byte 1 bits 3:0 carry analog 9:6 and bits 5:4 carry logic 1:0. Byte 2 bits 5:0 carry logic 7:2.
- R12: The ready state persists after a dump, and a repeated dump returns identical bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control value write strobe |
| ctrl_wdata | input | 8 | Control value (bit 0 FSM reset, bit 1 arm, bit 3 force) |
| trig_i | input | 1 | Trigger pulse |
| smp_valid | input | 1 | Sample present this cycle |
| smp_analog | input | 10 | Analog part of the sample |
| smp_logic | input | 8 | Logic part of the sample |
| status_req | input | 1 | Status query pulse |
| status_valid | output | 1 | Status byte valid |
| status_byte | output | 8 | Capture state code |
| dump_req | input | 1 | Dump command pulse |
| dout_valid | output | 1 | Dump byte valid |
| dout_byte | output | 8 | Dump byte |

## Verification
A wrong state register shows up at the next status query, one cycle after the request. A miscounted fill phase also shows there, as a filling, waiting or ready code that appears one sample too early or too late. A wrong write pointer or read base is not visible until a dump. It then shows as a rotated byte stream on the very first dumped byte. A broken byte packer corrupts a field within the first three bytes of the dump.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_POST  = 3'd3,
        ST_READY = 3'd4
    } cap_state_e;

    localparam int CTL_W         = 8;
    localparam int BYTE_W        = 8;
    localparam int ANA_W         = 10;
    localparam int LOG_W         = 8;
    localparam int ENTRY_W       = 3 * BYTE_W;
    localparam int CTL_RST_BIT   = 0;
    localparam int CTL_ARM_BIT   = 1;
    localparam int CTL_FORCE_BIT = 3;

    // Packs one sample into its three output bytes, lowest byte sent first.
    function automatic logic [ENTRY_W-1:0] pack_sample(
        input logic [ANA_W-1:0] ana,
        input logic [LOG_W-1:0] lg
    );
        logic [BYTE_W-1:0] b0, b1, b2;
        b0 = {2'b00, ana[5:0]};
        b1 = {2'b00, lg[1:0], ana[9:6]};
        b2 = {2'b00, lg[7:2]};
        return {b2, b1, b0};
    endfunction
endpackage

// File: rtl/cap_sample_ram.sv
module cap_sample_ram #(
    parameter int DEPTH  = 1024,
    parameter int WIDTH  = 24,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cap_ctrl_fsm.sv
module cap_ctrl_fsm
    import cap_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int PRE_N  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTL_W-1:0]  ctrl_wdata,
    input  logic              trig_i,
    input  logic              smp_valid,
    input  logic              status_req,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output cap_state_e        state,
    output logic              status_valid,
    output logic [BYTE_W-1:0] status_byte
);
    localparam int CNT_W     = ADDR_W + 1;
    localparam int POST_N    = DEPTH - PRE_N;
    localparam int PRE_LAST  = PRE_N - 1;
    localparam int POST_LAST = POST_N - 1;

    typedef struct packed {
        cap_state_e        st;
        logic [CTL_W-1:0]  ctl;
        logic [ADDR_W-1:0] wp;
        logic [CNT_W-1:0]  cnt;
        logic              sv;
        logic [BYTE_W-1:0] sb;
    } fsm_regs_t;

    localparam fsm_regs_t RST_VAL = '{st: ST_IDLE, ctl: '0, wp: '0, cnt: '0, sv: 1'b0, sb: '0};

    fsm_regs_t r_d, r_q;
    logic [CTL_W-1:0] ctl_eff;
    logic arm_rise, force_rise, store_c;

    always_comb begin
        r_d        = r_q;
        ctl_eff    = ctrl_we ? ctrl_wdata : r_q.ctl;
        arm_rise   = ctrl_we & ctrl_wdata[CTL_ARM_BIT] & ~r_q.ctl[CTL_ARM_BIT];
        force_rise = ctrl_we & ctrl_wdata[CTL_FORCE_BIT] & ~r_q.ctl[CTL_FORCE_BIT];
        store_c    = smp_valid & ((r_q.st == ST_FILL) | (r_q.st == ST_WAIT) | (r_q.st == ST_POST));

        r_d.ctl = ctl_eff;
        r_d.sv  = status_req;
        if (status_req) begin
            r_d.sb = {5'b00000, r_q.st};
        end
        if (store_c) begin
            r_d.wp = r_q.wp + 1'b1;
        end

        if (ctl_eff[CTL_RST_BIT]) begin
            r_d.st  = ST_IDLE;
            r_d.cnt = '0;
        end else if (arm_rise) begin
            r_d.st  = ST_FILL;
            r_d.wp  = '0;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_FILL: begin
                    if (force_rise) begin
                        r_d.st  = ST_POST;
                        r_d.cnt = '0;
                    end else if (store_c) begin
                        if (r_q.cnt == CNT_W'(PRE_LAST)) begin
                            r_d.st  = ST_WAIT;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (trig_i || force_rise) begin
                        r_d.st  = ST_POST;
                        r_d.cnt = '0;
                    end
                end
                ST_POST: begin
                    if (store_c) begin
                        if (r_q.cnt == CNT_W'(POST_LAST)) begin
                            r_d.st  = ST_READY;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en        = store_c;
    assign wr_addr      = r_q.wp;
    assign state        = r_q.st;
    assign status_valid = r_q.sv;
    assign status_byte  = r_q.sb;
endmodule

// File: rtl/cap_dump_seq.sv
module cap_dump_seq
    import cap_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               ready,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [ENTRY_W-1:0] rdata,
    output logic [ADDR_W-1:0]  raddr,
    output logic               dout_valid,
    output logic [BYTE_W-1:0]  dout_byte
);
    localparam logic [ADDR_W-1:0] LAST_SAMP = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              act;
        logic              prime;
        logic [ADDR_W-1:0] samp;
        logic [1:0]        bidx;
        logic [ADDR_W-1:0] base;
    } dump_regs_t;

    localparam dump_regs_t RST_VAL = '{act: 1'b0, prime: 1'b0, samp: '0, bidx: '0, base: '0};

    dump_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!ready) begin
            r_d.act   = 1'b0;
            r_d.prime = 1'b0;
        end else if (!r_q.act) begin
            if (start_req) begin
                r_d.act   = 1'b1;
                r_d.prime = 1'b1;
                r_d.samp  = '0;
                r_d.bidx  = '0;
                r_d.base  = base_addr;
            end
        end else if (r_q.prime) begin
            r_d.prime = 1'b0;
        end else if (r_q.bidx == 2'd2) begin
            r_d.bidx = '0;
            if (r_q.samp == LAST_SAMP) begin
                r_d.act = 1'b0;
            end else begin
                r_d.samp = r_q.samp + 1'b1;
            end
        end else begin
            r_d.bidx = r_q.bidx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    // Prefetch the next entry while the last byte of the current one is out.
    assign raddr = r_q.base + r_q.samp + {{(ADDR_W-1){1'b0}}, (r_q.bidx == 2'd2)};

    assign dout_valid = r_q.act & ~r_q.prime & ready;

    always_comb begin
        unique case (r_q.bidx)
            2'd0:    dout_byte = rdata[BYTE_W-1:0];
            2'd1:    dout_byte = rdata[2*BYTE_W-1:BYTE_W];
            default: dout_byte = rdata[3*BYTE_W-1:2*BYTE_W];
        endcase
    end
endmodule

// File: rtl/armed_capture_ctrl.sv
module armed_capture_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int PRE_SAMPLES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic              trig_i,
    input  logic              smp_valid,
    input  logic [9:0]        smp_analog,
    input  logic [7:0]        smp_logic,
    input  logic              status_req,
    output logic              status_valid,
    output logic [7:0]        status_byte,
    input  logic              dump_req,
    output logic              dout_valid,
    output logic [7:0]        dout_byte
);
    localparam int ADDR_W = $clog2(DEPTH);

    cap_state_e         fsm_state;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [ADDR_W-1:0]  rd_addr;
    logic [ENTRY_W-1:0] rd_data;
    logic [ENTRY_W-1:0] wr_data;

    assign wr_data = pack_sample(smp_analog, smp_logic);

    cap_ctrl_fsm #(
        .DEPTH (DEPTH),
        .PRE_N (PRE_SAMPLES),
        .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .trig_i      (trig_i),
        .smp_valid   (smp_valid),
        .status_req  (status_req),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .state       (fsm_state),
        .status_valid(status_valid),
        .status_byte (status_byte)
    );

    cap_sample_ram #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    cap_dump_seq #(
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_dump (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (dump_req),
        .ready     (fsm_state == ST_READY),
        .base_addr (wr_addr),
        .rdata     (rd_data),
        .raddr     (rd_addr),
        .dout_valid(dout_valid),
        .dout_byte (dout_byte)
    );
endmodule

// File: rtl/cap_checker.sv
module cap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic       status_req,
    input logic       status_valid,
    input logic [7:0] status_byte,
    input logic       dout_valid,
    input logic [7:0] dout_byte,
    input logic [2:0] fsm_state,
    input logic       wr_en
);
    a_r9_reply_follows_query: assert property (@(posedge clk) disable iff (!rst_n)
        status_req |=> status_valid);

    a_r9_no_unasked_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !status_req |=> !status_valid);

    a_r9_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> (status_byte <= 8'd4));

    a_r2_reset_bit_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[0]) |=> (fsm_state == 3'd0));

    a_r11_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (dout_byte[7:6] == 2'b00));

    a_r10_dump_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (fsm_state == 3'd4));

    a_r7_no_store_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == 3'd4) |-> !wr_en);
endmodule

bind armed_capture_ctrl cap_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .status_req  (status_req),
    .status_valid(status_valid),
    .status_byte (status_byte),
    .dout_valid  (dout_valid),
    .dout_byte   (dout_byte),
    .fsm_state   (fsm_state),
    .wr_en       (wr_en)
);

// File: tb/tb_armed_capture_ctrl.sv
`timescale 1ns/1ps
module tb_armed_capture_ctrl;
    localparam int DEPTH = 1024;
    localparam int PRE   = 512;
    localparam int POST  = DEPTH - PRE;
    localparam int NBYTE = 3 * DEPTH;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctrl_we;
    logic [7:0] ctrl_wdata;
    logic       trig_i;
    logic       smp_valid;
    logic [9:0] smp_analog;
    logic [7:0] smp_logic;
    logic       status_req;
    logic       status_valid;
    logic [7:0] status_byte;
    logic       dump_req;
    logic       dout_valid;
    logic [7:0] dout_byte;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [9:0] m_a [DEPTH];
    logic [7:0] m_l [DEPTH];
    int wp = 0;

    armed_capture_ctrl #(.DEPTH(DEPTH), .PRE_SAMPLES(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .trig_i(trig_i), .smp_valid(smp_valid), .smp_analog(smp_analog),
        .smp_logic(smp_logic), .status_req(status_req), .status_valid(status_valid),
        .status_byte(status_byte), .dump_req(dump_req), .dout_valid(dout_valid),
        .dout_byte(dout_byte)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_byte(input logic [9:0] a, input logic [7:0] l, input int k);
        if (k == 0) return {2'b00, a[5:0]};
        if (k == 1) return {2'b00, l[1:0], a[9:6]};
        return {2'b00, l[7:2]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
    endtask

    task automatic expect_status(input logic [7:0] exp, input string req);
        logic [7:0] s;
        logic v;
        @(negedge clk); status_req = 1'b1;
        @(negedge clk); s = status_byte; v = status_valid; status_req = 1'b0;
        check(v && (s == exp), req, v ? int'(s) : 'hff, int'(exp));
    endtask

    task automatic feed(input int n, input bit stored);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk); smp_valid = 1'b0;
            end
            @(negedge clk);
            smp_valid  = 1'b1;
            smp_analog = 10'($urandom);
            smp_logic  = 8'($urandom);
            if (stored) begin
                m_a[wp] = smp_analog;
                m_l[wp] = smp_logic;
                wp = (wp + 1) % DEPTH;
            end
        end
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic arm_seq();
        ctl_write(8'h01);
        ctl_write(8'h02);
        ctl_write(8'h00);
        wp = 0;
    endtask

    task automatic do_dump(input bit expect_data, input string req);
        int n = 0;
        int first_c = -1;
        int bad_at = -1;
        int bad_act = 0;
        int bad_exp = 0;
        @(negedge clk); dump_req = 1'b1;
        @(negedge clk); dump_req = 1'b0;
        for (int c = 0; c < NBYTE + 8; c++) begin
            @(negedge clk);
            if (dout_valid) begin
                if (first_c < 0) first_c = c;
                if (n < NBYTE) begin
                    int idx = (wp + n / 3) % DEPTH;
                    logic [7:0] e = exp_byte(m_a[idx], m_l[idx], n % 3);
                    if (dout_byte !== e && bad_at < 0) begin
                        bad_at = n; bad_act = int'(dout_byte); bad_exp = int'(e);
                    end
                end
                n++;
            end
        end
        if (expect_data) begin
            check(n == NBYTE, {req, " byte count"}, n, NBYTE);
            check(first_c == 0, {req, " first byte cycle"}, first_c, 0);
            check(bad_at < 0, {req, " byte content (R11 layout, oldest first)"}, bad_act, bad_exp);
        end else begin
            check(n == 0, {req, " dump ignored"}, n, 0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; trig_i = 1'b0;
        smp_valid = 1'b0; smp_analog = '0; smp_logic = '0;
        status_req = 1'b0; dump_req = 1'b0;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(dout_valid == 1'b0, "R1 dout_valid after reset", int'(dout_valid), 0);
        check(status_valid == 1'b0, "R9 no reply without query", int'(status_valid), 0);
        expect_status(8'h00, "R1 status after reset");
        do_dump(1'b0, "R10 idle");

        // Capture 1: trigger path with wrap
        arm_seq();
        expect_status(8'h01, "R3 filling after arm");
        feed(100, 1'b1);
        pulse_trig();
        expect_status(8'h01, "R4 trigger ignored while filling");
        feed(PRE - 100, 1'b1);
        expect_status(8'h02, "R4 waiting after pre samples");
        feed(700, 1'b1);
        expect_status(8'h02, "R5 still waiting while wrapping");
        pulse_trig();
        expect_status(8'h03, "R5 post after trigger");
        feed(POST - 1, 1'b1);
        expect_status(8'h03, "R7 one sample short");
        feed(1, 1'b1);
        expect_status(8'h04, "R7 ready after post samples");
        feed(5, 1'b0);
        expect_status(8'h04, "R7 ready holds after extra samples");
        do_dump(1'b1, "R10 capture 1");
        do_dump(1'b1, "R12 repeated dump");
        expect_status(8'h04, "R12 ready after dump");

        // Capture 2: force from filling, bits left set
        ctl_write(8'h01);
        ctl_write(8'h02);
        wp = 0;
        expect_status(8'h01, "R3 armed with arm bit held");
        feed(50, 1'b1);
        ctl_write(8'h0A);
        expect_status(8'h03, "R6 force from filling");
        feed(POST, 1'b1);
        expect_status(8'h04, "R7 ready after forced capture");
        ctl_write(8'h0A);
        expect_status(8'h04, "R8 held arm and force ignored");
        do_dump(1'b1, "R6 forced capture dump");

        // Capture 3: force from waiting, then FSM reset in post
        ctl_write(8'h01);
        ctl_write(8'h02);
        wp = 0;
        feed(PRE, 1'b1);
        expect_status(8'h02, "R4 waiting capture 3");
        ctl_write(8'h0A);
        expect_status(8'h03, "R6 force from waiting");
        feed(10, 1'b1);
        ctl_write(8'h01);
        expect_status(8'h00, "R2 FSM reset from post");
        do_dump(1'b0, "R10 after reset");

        // Capture 4: reset priority, held arm, random wait length
        ctl_write(8'h03);
        expect_status(8'h00, "R2 reset wins over arm");
        ctl_write(8'h02);
        expect_status(8'h00, "R8 arm without rising edge");
        ctl_write(8'h00);
        ctl_write(8'h02);
        wp = 0;
        expect_status(8'h01, "R3 arm after clear");
        feed(PRE + $urandom_range(0, 1500), 1'b1);
        expect_status(8'h02, "R5 waiting random length");
        pulse_trig();
        feed(POST, 1'b1);
        expect_status(8'h04, "R7 ready capture 4");
        do_dump(1'b1, "R10 capture 4");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule